// File: doc/BRIEF.md
# Pulse-Swallow Programmable Clock Divider

This block divides a fast input clock by an integer ratio N = P·B + A and issues one output pulse per N input cycles, as in the feedback path of a frequency synthesizer. A two-modulus prescaler counts either P+1 or P input cycles per prescaler cycle. A swallow counter keeps the prescaler at P+1 for the first A prescaler cycles of each output period, and a main counter ends the period after B prescaler cycles. The base modulus P is a power of two picked by a select input.

Software-side logic writes a swallow count, a main count and a prescaler select, then pulses a load strobe. The captured values wait in a pending slot and take over only when the running output period ends, so a period in progress is never cut short. When no period is running, because the divider is disabled (B = 0) or holds an illegal pair (A > B), a pending setting starts a new period on the next cycle. An illegal pair raises an error flag and silences the divider until a legal setting arrives.

Top module: `pswallow_div`

## Requirements
- R1: While running, consecutive rising pulses on `div_pulse` are exactly P·B + A input cycles apart, where P = 2^(2 + `psel`), giving P = 4, 8, 16 or 32 for `psel` = 0..3.
- R2: `div_pulse` is high for exactly one input cycle per output period.
- R3: Within each output period `mod_hi` is high for the first A prescaler cycles, which is A·(P+1) input cycles beginning with the cycle that carries the pulse. It is low for the other B − A prescaler cycles, and it changes only at a prescaler cycle boundary.
- R4: With A = 0, `mod_hi` stays low for the whole period and the ratio is P·B (for example P = 8, B = 9 gives 72 and B = 1 gives 8).
- R5: With B = 0 and A = 0 the divider is disabled: no pulses, `mod_hi` low, `cfg_err` low.
- R6: When the active pair has A > B, `cfg_err` is high, `mod_hi` is low and no pulse is issued after the cycle in which that pair took over.
- R7: Values captured by `load` while a period runs take effect only at the end of that period, and the length of that period is unchanged.
- R8: From the disabled or illegal state, the first pulse after a legal load appears N + 2 cycles after the cycle in which `load` was high.
- R9: After synchronous reset, `div_pulse`, `mod_hi` and `cfg_err` are low and the divider is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock |
| rst | input | 1 | Synchronous reset, active high |
| load | input | 1 | Strobe capturing `swal_in`, `main_in` and `psel` into the pending slot |
| swal_in | input | CNT_W | Swallow count A |
| main_in | input | CNT_W | Main count B |
| psel | input | PSEL_W | Prescaler base select, P = 2^(P_LOG2_MIN + psel) |
| div_pulse | output | 1 | One-cycle pulse per output period |
| mod_hi | output | 1 | Registered modulus control, high while the prescaler divides by P+1 |
| cfg_err | output | 1 | Active pair has A > B |

## Verification
The hardest case to reach is a load that arrives partway through a running period. The stimulus lets a 90-cycle period start, waits twenty cycles, loads a much shorter ratio, and checks that the old period still runs its full length and only the period after it is shorter. The entries into and out of the illegal state are also reached on purpose. An illegal pair is loaded behind a running period, and the bench then counts the cycles from the next legal load to the first pulse. A behavioural model that counts straight to N on every clock checks every output in every cycle, including the A = B case, where the prescaler never leaves P+1.

// File: rtl/pswallow_pkg.sv
package pswallow_pkg;

   // Width needed to hold P+1 for the largest selectable base modulus.
   function automatic int pval_bits(input int lmin, input int selw);
      return lmin + (1 << selw);
   endfunction

   // A legal pair keeps the swallow count within the main count.
   function automatic bit pair_runs(input int unsigned a, input int unsigned b);
      return (b != 0) && (a <= b);
   endfunction

endpackage

// File: rtl/psw_cfg.sv
module psw_cfg #(
   parameter int CNT_W  = 8,
   parameter int PSEL_W = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              load,
   input  logic [CNT_W-1:0]  swal_in,
   input  logic [CNT_W-1:0]  main_in,
   input  logic [PSEL_W-1:0] psel_in,
   input  logic              take,
   output logic [PSEL_W-1:0] act_sel,
   output logic [CNT_W-1:0]  nxt_a,
   output logic [CNT_W-1:0]  nxt_b,
   output logic              pend_v,
   output logic              runnable,
   output logic              bad
);
   logic [CNT_W-1:0]  pnd_a, pnd_b, cur_a, cur_b;
   logic [PSEL_W-1:0] pnd_sel;

   always_ff @(posedge clk) begin
      if (rst) begin
         pnd_a   <= '0;
         pnd_b   <= '0;
         pnd_sel <= '0;
         pend_v  <= 1'b0;
         cur_a   <= '0;
         cur_b   <= '0;
         act_sel <= '0;
      end else begin
         if (take && pend_v) begin
            cur_a   <= pnd_a;
            cur_b   <= pnd_b;
            act_sel <= pnd_sel;
         end
         if (load) begin
            pnd_a   <= swal_in;
            pnd_b   <= main_in;
            pnd_sel <= psel_in;
            pend_v  <= 1'b1;
         end else if (take && pend_v) begin
            pend_v  <= 1'b0;
         end
      end
   end

   assign nxt_a    = pend_v ? pnd_a : cur_a;
   assign nxt_b    = pend_v ? pnd_b : cur_b;
   assign runnable = pswallow_pkg::pair_runs(int'(cur_a), int'(cur_b));
   assign bad      = (cur_a > cur_b);
endmodule

// File: rtl/psw_prescaler.sv
module psw_prescaler #(
   parameter int PV_W = 6
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            run,
   input  logic            restart,
   input  logic            mod_hi,
   input  logic [PV_W-1:0] p_val,
   output logic            pre_tc
);
   logic [PV_W-1:0] cnt;
   logic [PV_W-1:0] last;

   // Last count value of this prescaler cycle: P for P+1, P-1 for P.
   assign last   = mod_hi ? p_val : (p_val - PV_W'(1));
   assign pre_tc = run && (cnt == last);

   always_ff @(posedge clk) begin
      if (rst)                  cnt <= '0;
      else if (restart||pre_tc) cnt <= '0;
      else if (run)             cnt <= cnt + PV_W'(1);
   end
endmodule

// File: rtl/psw_seq.sv
module psw_seq #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             pre_tc,
   input  logic             runnable,
   input  logic             pend_v,
   input  logic [CNT_W-1:0] nxt_a,
   input  logic [CNT_W-1:0] nxt_b,
   output logic             take,
   output logic             idle,
   output logic             mod_hi,
   output logic             div_pulse
);
   logic [CNT_W-1:0] main_cnt, swal_cnt;
   logic             terminal, start, nxt_ok;

   assign idle     = !runnable;
   assign start    = idle && pend_v;
   assign terminal = runnable && pre_tc && (main_cnt == CNT_W'(1));
   assign take     = start || terminal;
   assign nxt_ok   = pswallow_pkg::pair_runs(int'(nxt_a), int'(nxt_b));

   always_ff @(posedge clk) begin
      if (rst) begin
         main_cnt  <= '0;
         swal_cnt  <= '0;
         mod_hi    <= 1'b0;
         div_pulse <= 1'b0;
      end else begin
         div_pulse <= terminal;
         if (take) begin
            main_cnt <= nxt_b;
            swal_cnt <= nxt_a;
            mod_hi   <= nxt_ok && (nxt_a != '0);
         end else if (runnable && pre_tc) begin
            main_cnt <= main_cnt - CNT_W'(1);
            if (swal_cnt != '0) swal_cnt <= swal_cnt - CNT_W'(1);
            mod_hi   <= (swal_cnt > CNT_W'(1));
         end
      end
   end
endmodule

// File: rtl/pswallow_div.sv
module pswallow_div #(
   parameter int CNT_W      = 8,
   parameter int PSEL_W     = 2,
   parameter int P_LOG2_MIN = 2,
   parameter bit FIXED_P    = 1'b0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              load,
   input  logic [CNT_W-1:0]  swal_in,
   input  logic [CNT_W-1:0]  main_in,
   input  logic [PSEL_W-1:0] psel,
   output logic              div_pulse,
   output logic              mod_hi,
   output logic              cfg_err
);
   localparam int PV_W = pswallow_pkg::pval_bits(P_LOG2_MIN, PSEL_W);

   if (CNT_W < 1 || CNT_W > 16) begin : g_bad_cnt
      $error("CNT_W must lie in 1..16");
   end
   if (PSEL_W < 1 || PSEL_W > 3) begin : g_bad_sel
      $error("PSEL_W must lie in 1..3");
   end
   if (P_LOG2_MIN < 1 || P_LOG2_MIN > 8) begin : g_bad_p
      $error("P_LOG2_MIN must lie in 1..8");
   end

   logic [PSEL_W-1:0] act_sel;
   logic [CNT_W-1:0]  nxt_a, nxt_b;
   logic              pend_v, runnable, take, idle, pre_tc;
   logic [PV_W-1:0]   p_val;

   psw_cfg #(.CNT_W(CNT_W), .PSEL_W(PSEL_W)) u_cfg (
      .clk(clk), .rst(rst), .load(load),
      .swal_in(swal_in), .main_in(main_in), .psel_in(psel),
      .take(take), .act_sel(act_sel), .nxt_a(nxt_a), .nxt_b(nxt_b),
      .pend_v(pend_v), .runnable(runnable), .bad(cfg_err)
   );

   if (FIXED_P) begin : g_p_fixed
      assign p_val = PV_W'(1) << P_LOG2_MIN;
   end else begin : g_p_sel
      assign p_val = PV_W'(1) << (P_LOG2_MIN + int'(act_sel));
   end

   psw_prescaler #(.PV_W(PV_W)) u_pre (
      .clk(clk), .rst(rst), .run(runnable), .restart(take),
      .mod_hi(mod_hi), .p_val(p_val), .pre_tc(pre_tc)
   );

   psw_seq #(.CNT_W(CNT_W)) u_seq (
      .clk(clk), .rst(rst), .pre_tc(pre_tc), .runnable(runnable),
      .pend_v(pend_v), .nxt_a(nxt_a), .nxt_b(nxt_b),
      .take(take), .idle(idle), .mod_hi(mod_hi), .div_pulse(div_pulse)
   );
endmodule

// File: rtl/pswallow_div_chk.sv
module pswallow_div_chk (
   input logic clk,
   input logic rst,
   input logic div_pulse,
   input logic mod_hi,
   input logic cfg_err,
   input logic pre_tc,
   input logic idle
);
   AST_PULSE_AT_TC: assert property (@(posedge clk) disable iff (rst)
      div_pulse |-> $past(pre_tc)); // R1
   AST_PULSE_ONE_WIDE: assert property (@(posedge clk) disable iff (rst)
      div_pulse |=> !div_pulse); // R2
   AST_MOD_AT_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
      (mod_hi != $past(mod_hi)) |-> ($past(pre_tc) || $past(idle))); // R3
   AST_IDLE_NO_PULSE: assert property (@(posedge clk) disable iff (rst)
      idle |=> !div_pulse); // R5
   AST_ERR_NO_MOD: assert property (@(posedge clk) disable iff (rst)
      cfg_err |-> !mod_hi); // R6
   AST_ERR_NO_PULSE: assert property (@(posedge clk) disable iff (rst)
      (cfg_err && $past(cfg_err)) |-> !div_pulse); // R6
endmodule

bind pswallow_div pswallow_div_chk u_chk (
   .clk(clk), .rst(rst), .div_pulse(div_pulse), .mod_hi(mod_hi),
   .cfg_err(cfg_err), .pre_tc(pre_tc), .idle(idle)
);

// File: tb/tb_pswallow_div.sv
module tb_pswallow_div;
   localparam int CLK_PERIOD = 10;
   localparam int CNT_W  = 8;
   localparam int PSEL_W = 2;
   localparam int WATCHDOG = 150000;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic load = 1'b0;
   logic [CNT_W-1:0]  swal_in = '0, main_in = '0;
   logic [PSEL_W-1:0] psel = '0;
   logic div_pulse, mod_hi, cfg_err;

   int total = 0, bad = 0, cyc = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pswallow_div dut (
      .clk(clk), .rst(rst), .load(load), .swal_in(swal_in),
      .main_in(main_in), .psel(psel), .div_pulse(div_pulse),
      .mod_hi(mod_hi), .cfg_err(cfg_err)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
      end
   endtask

   // Behavioural reference: one period counter running straight to N.
   int m_a = 0, m_b = 0, m_p = 4, q_a = 0, q_b = 0, q_p = 4;
   bit q_v = 0, e_pulse = 0, started = 0;
   int k = 0;

   function automatic bit m_runs();
      return (m_b != 0) && (m_a <= m_b);
   endfunction

   always @(posedge clk) begin
      cyc++;
      if (rst) begin
         m_a = 0; m_b = 0; m_p = 4; q_v = 0; e_pulse = 0; k = 0;
         started = 1;
      end else begin
         if (!m_runs()) begin
            e_pulse = 0;
            if (q_v) begin m_a = q_a; m_b = q_b; m_p = q_p; q_v = 0; k = 0; end
         end else if (k == m_p*m_b + m_a - 1) begin
            e_pulse = 1; k = 0;
            if (q_v) begin m_a = q_a; m_b = q_b; m_p = q_p; q_v = 0; end
         end else begin
            e_pulse = 0; k++;
         end
         if (load) begin
            q_a = int'(swal_in); q_b = int'(main_in); q_p = 1 << (2 + int'(psel)); q_v = 1;
         end
      end
   end

   always @(negedge clk) begin
      if (started) begin
         bit e_mod;
         e_mod = m_runs() && (k < m_a*(m_p+1));
         check(div_pulse == e_pulse, "R1 cycle model pulse", int'(div_pulse), int'(e_pulse));
         check(mod_hi == e_mod, "R3 cycle model mod_hi", int'(mod_hi), int'(e_mod));
         check(cfg_err == (m_a > m_b), "R6 cycle model cfg_err", int'(cfg_err), int'(m_a > m_b));
      end
   end

   always @(posedge clk) begin
      if (cyc > WATCHDOG) begin
         bad++; total++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, WATCHDOG);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   task automatic do_load(input int sel, input int a, input int b);
      @(negedge clk);
      load = 1'b1; psel = PSEL_W'(sel); swal_in = CNT_W'(a); main_in = CNT_W'(b);
      @(negedge clk);
      load = 1'b0;
   endtask

   task automatic wait_pulse();
      do @(negedge clk); while (!div_pulse);
   endtask

   task automatic measure(input int sel, input int a, input int b);
      int p, n, cnt, hi;
      p = 1 << (2 + sel);
      n = p*b + a;
      wait_pulse();
      hi = int'(mod_hi);
      cnt = 0;
      do begin
         @(negedge clk);
         cnt++;
         if (cnt == 1) check(!div_pulse, "R2 pulse width", int'(div_pulse), 0);
         if (!div_pulse) hi += int'(mod_hi);
      end while (!div_pulse);
      check(cnt == n, "R1 pulse interval", cnt, n);
      if (a == 0) check(hi == 0, "R4 mod_hi idle when A=0", hi, 0);
      else        check(hi == a*(p+1), "R3 mod_hi cycles per period", hi, a*(p+1));
   endtask

   int rows_a[11] = '{2, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0};
   int rows_b[11] = '{11, 10, 9, 8, 7, 6, 5, 4, 3, 2, 1};

   initial begin
      int cnt, pulses, hi;
      repeat (4) @(negedge clk);
      rst = 1'b0;
      check(!div_pulse && !mod_hi && !cfg_err, "R9 reset state",
            int'({div_pulse, mod_hi, cfg_err}), 0);

      pulses = 0;
      repeat (30) begin @(negedge clk); pulses += int'(div_pulse); end
      check(pulses == 0, "R5 disabled after reset", pulses, 0);

      for (int i = 0; i < 11; i++) begin
         do_load(1, rows_a[i], rows_b[i]);
         measure(1, rows_a[i], rows_b[i]);
         measure(1, rows_a[i], rows_b[i]);
      end
      do_load(0, 3, 5);  measure(0, 3, 5);  measure(0, 3, 5);
      do_load(2, 4, 4);  measure(2, 4, 4);  measure(2, 4, 4);
      do_load(3, 1, 2);  measure(3, 1, 2);  measure(3, 1, 2);

      // R7: load in mid-period must not shorten the running period
      do_load(1, 2, 11);
      wait_pulse();
      wait_pulse();
      cnt = 0;
      repeat (20) begin @(negedge clk); cnt++; end
      do_load(1, 0, 1);
      cnt += 2;
      while (!div_pulse) begin @(negedge clk); cnt++; end
      check(cnt == 90, "R7 running period kept", cnt, 90);
      measure(1, 0, 1);

      // R6: illegal pair silences the divider
      do_load(1, 5, 3);
      wait_pulse();
      @(negedge clk);
      check(cfg_err, "R6 error flag", int'(cfg_err), 1);
      pulses = 0; hi = 0;
      repeat (60) begin
         @(negedge clk); pulses += int'(div_pulse); hi += int'(mod_hi);
      end
      check(pulses == 0, "R6 no pulses", pulses, 0);
      check(hi == 0, "R6 mod_hi low", hi, 0);

      // R8: start-up latency from the illegal state
      @(negedge clk);
      load = 1'b1; psel = 2'd0; swal_in = 8'd1; main_in = 8'd2;
      cnt = 0;
      do begin
         @(negedge clk); cnt++;
         if (cnt == 1) load = 1'b0;
      end while (!div_pulse && cnt < 1000);
      check(cnt == 11, "R8 first pulse latency", cnt, 11);
      check(!cfg_err, "R8 error cleared", int'(cfg_err), 0);

      // R5: disable after running
      do_load(1, 0, 0);
      wait_pulse();
      pulses = 0; hi = 0;
      repeat (80) begin
         @(negedge clk); pulses += int'(div_pulse); hi += int'(mod_hi) + int'(cfg_err);
      end
      check(pulses == 0, "R5 disabled no pulses", pulses, 0);
      check(hi == 0, "R5 disabled mod_hi and cfg_err low", hi, 0);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule